// File: doc/BRIEF.md
# Byte-Staged Pulse Period Register with Reloading Down-Counter

This block keeps the 16-bit period of a programmable pulse generator and runs the down-counter that uses it. A narrow CPU bus reaches the period either as two byte registers (upper half at address 1, lower half at address 0) or as one 16-bit word aimed at address 1. An upper-byte write goes into a staging register and waits for the matching lower-byte write, so a reload that lands in the middle of a correctly ordered byte update still sees the previous complete period.

The down-counter starts from the valid period when the run input rises. It counts down once per tick and reloads from the valid period at the end of each cycle, raising a one-clock end-of-period strobe. Period changes therefore take effect only at the next reload. An error output flags the two period values that the pulse generator cannot use.

Top module: `ppb_top`

## Requirements
- R1: After synchronous reset the valid period is 0xFFFF, no upper byte is staged, `count` is 0, and `eop` and `cfg_err` are low.
- R2: A write with `bus_word`=1 and `bus_addr`=1 replaces all 16 bits of the valid period in one clock and discards any staged upper byte. A word write with `bus_addr`=0 is ignored.
- R3: Reads are combinational and return the valid period, never the staged byte. A byte read (`bus_word`=0) returns bits 15..8 on `bus_rdata[7:0]` for `bus_addr`=1 and bits 7..0 for `bus_addr`=0, with `bus_rdata[15:8]`=0. A word read at `bus_addr`=1 returns all 16 bits.
- R4: A byte write to address 1 only stages the upper byte. The valid period is unchanged, and a reload before the lower-byte write loads the previous complete period.
- R5: A byte write to address 0 while an upper byte is staged commits the staged upper byte and the new lower byte to the valid period in the same clock and clears the staged state.
- R6: A byte write to address 0 with nothing staged changes only bits 7..0 of the valid period, at once. The next reload then uses the old upper byte together with the new lower byte.
- R7: In the clock where `run` rises, `count` is loaded with the valid period and `tick` is ignored.
- R8: While `run` is high, each `tick` lowers `count` by one. A `tick` with `count` at 1 (or 0) reloads `count` from the valid period and sets `eop` high for the next clock only. With period P and ticks on every clock, `eop` repeats every P clocks.
- R9: A period change during a running cycle does not alter that cycle. The new value is used from the next reload.
- R10: `cfg_err` is high for as long as the valid period holds 0x0000 or 0x0101. Such values are still stored and read back.
- R11: While `run` is low, `count` is 0 and `eop` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, one clock per access |
| bus_word | input | 1 | 1 = 16-bit access, 0 = byte access |
| bus_addr | input | 1 | 1 = upper byte / word address, 0 = lower byte |
| bus_wdata | input | 16 | Write data; byte writes use bits 7..0 |
| bus_rdata | output | 16 | Read data for the current address and size |
| run | input | 1 | Counter enable; rising edge starts a cycle |
| tick | input | 1 | Count-enable pulse |
| count | output | 16 | Present down-counter value |
| eop | output | 1 | One-clock end-of-period strobe |
| cfg_err | output | 1 | Valid period is an unusable value |

## Verification
The bench targets reloads that fall between the two halves of a byte-wise update. In the upper-then-lower order, a design that writes the upper byte straight through would reload a period of 0x0107 where 0x0007 is expected. In the lower-then-upper order, a design that also staged the lower byte would reload the old period instead of the mixed 0x0109. The bench also changes the period in the middle of a cycle, where a design that loads the new value at once would shorten the running cycle. It runs with a tick on every other clock to catch a counter that decrements on the clock instead of on the tick. It also checks that the two unusable periods are flagged but still stored, and that a word write to the lower address has no effect.

// File: rtl/ppb_pkg.sv
package ppb_pkg;

    localparam int PERIOD_W = 16;
    localparam int HALF_W   = PERIOD_W / 2;

    typedef logic [PERIOD_W-1:0] period_t;
    typedef logic [HALF_W-1:0]   half_t;

    // Kind of register access presented in a clock
    typedef enum logic [1:0] {
        ACC_NONE = 2'd0,
        ACC_WORD = 2'd1,
        ACC_HI   = 2'd2,
        ACC_LO   = 2'd3
    } acc_kind_e;

    typedef struct packed {
        acc_kind_e kind;
        period_t   data;
    } wr_req_t;

    // Turn raw bus strobes into an access kind; word writes only count at address 1
    function automatic acc_kind_e decode_write(input logic wr, input logic word,
                                               input logic addr);
        acc_kind_e k;
        k = ACC_NONE;
        if (wr) begin
            if (word)      k = addr ? ACC_WORD : ACC_NONE;
            else if (addr) k = ACC_HI;
            else           k = ACC_LO;
        end
        return k;
    endfunction

    // Periods that cannot produce a usable waveform
    function automatic logic period_unusable(input period_t p);
        return (p == '0) || (p == {{(HALF_W-1){1'b0}}, 1'b1, {(HALF_W-1){1'b0}}, 1'b1});
    endfunction

endpackage

// File: rtl/ppb_regs.sv
module ppb_regs
    import ppb_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  wr_req_t req,
    output period_t valid_q,
    output logic    pend_q,
    output logic    err
);

    half_t stage_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= '1;
            stage_q <= '1;
            pend_q  <= 1'b0;
        end else begin
            unique case (req.kind)
                ACC_WORD: begin
                    valid_q <= req.data;
                    pend_q  <= 1'b0;
                end
                ACC_HI: begin
                    stage_q <= req.data[HALF_W-1:0];
                    pend_q  <= 1'b1;
                end
                ACC_LO: begin
                    if (pend_q) begin
                        valid_q <= {stage_q, req.data[HALF_W-1:0]};
                        pend_q  <= 1'b0;
                    end else begin
                        valid_q[HALF_W-1:0] <= req.data[HALF_W-1:0];
                    end
                end
                default: ;
            endcase
        end
    end

    assign err = period_unusable(valid_q);

    AST_HI_HOLDS_VALID: assert property (@(posedge clk) disable iff (rst)
        (req.kind == ACC_HI) |=> (valid_q == $past(valid_q))); // R4
    AST_LO_COMMIT_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (req.kind == ACC_LO && pend_q) |=> (!pend_q && valid_q[HALF_W-1:0] == $past(req.data[HALF_W-1:0]))); // R5
    AST_LO_KEEPS_UPPER: assert property (@(posedge clk) disable iff (rst)
        (req.kind == ACC_LO && !pend_q) |=> (valid_q[PERIOD_W-1:HALF_W] == $past(valid_q[PERIOD_W-1:HALF_W]))); // R6
    AST_WORD_REPLACES: assert property (@(posedge clk) disable iff (rst)
        (req.kind == ACC_WORD) |=> (valid_q == $past(req.data) && !pend_q)); // R2

endmodule

// File: rtl/ppb_readmux.sv
module ppb_readmux
    import ppb_pkg::*;
(
    input  period_t valid,
    input  logic    word,
    input  logic    addr,
    output period_t rdata
);

    always_comb begin
        rdata = '0;
        if (word) begin
            if (addr) rdata = valid;
        end else begin
            rdata[HALF_W-1:0] = addr ? valid[PERIOD_W-1:HALF_W] : valid[HALF_W-1:0];
        end
    end

endmodule

// File: rtl/ppb_counter.sv
module ppb_counter
    import ppb_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    run,
    input  logic    tick,
    input  period_t period,
    output period_t cnt_q,
    output logic    eop_q
);

    logic    run_q;
    logic    start;
    logic    at_end;

    assign start  = run && !run_q;
    assign at_end = (cnt_q <= period_t'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q <= 1'b0;
            cnt_q <= '0;
            eop_q <= 1'b0;
        end else begin
            run_q <= run;
            eop_q <= 1'b0;
            if (!run) begin
                cnt_q <= '0;
            end else if (start) begin
                cnt_q <= period;
            end else if (tick) begin
                if (at_end) begin
                    cnt_q <= period;
                    eop_q <= 1'b1;
                end else begin
                    cnt_q <= cnt_q - period_t'(1);
                end
            end
        end
    end

    AST_RELOAD_FROM_VALID: assert property (@(posedge clk) disable iff (rst)
        eop_q |-> (cnt_q == $past(period))); // R8
    AST_START_LOADS: assert property (@(posedge clk) disable iff (rst)
        (run && !run_q) |=> (cnt_q == $past(period) && !eop_q)); // R7
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !run |=> (cnt_q == '0 && !eop_q)); // R11
    AST_NO_TICK_HOLD: assert property (@(posedge clk) disable iff (rst)
        (run && run_q && !tick) |=> $stable(cnt_q)); // R8

endmodule

// File: rtl/ppb_top.sv
module ppb_top
    import ppb_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                bus_wr,
    input  logic                bus_word,
    input  logic                bus_addr,
    input  logic [PERIOD_W-1:0] bus_wdata,
    output logic [PERIOD_W-1:0] bus_rdata,
    input  logic                run,
    input  logic                tick,
    output logic [PERIOD_W-1:0] count,
    output logic                eop,
    output logic                cfg_err
);

    wr_req_t req;
    period_t valid;
    logic    pend;

    assign req.kind = decode_write(bus_wr, bus_word, bus_addr);
    assign req.data = bus_wdata;

    ppb_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .req     (req),
        .valid_q (valid),
        .pend_q  (pend),
        .err     (cfg_err)
    );

    ppb_readmux u_rmux (
        .valid (valid),
        .word  (bus_word),
        .addr  (bus_addr),
        .rdata (bus_rdata)
    );

    ppb_counter u_cnt (
        .clk    (clk),
        .rst    (rst),
        .run    (run),
        .tick   (tick),
        .period (valid),
        .cnt_q  (count),
        .eop_q  (eop)
    );

    AST_IGNORED_LOW_WORD: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_word && !bus_addr) |=> ($stable(valid) && $stable(pend))); // R2

endmodule

// File: tb/sim_ppb_top.sv
module sim_ppb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        bus_wr, bus_word, bus_addr;
    logic [15:0] bus_wdata, bus_rdata;
    logic        run, tick;
    logic [15:0] count;
    logic        eop, cfg_err;

    int nchk  = 0;
    int nfail = 0;
    int cyc   = 0;
    bit tick_alt = 1'b0;
    bit done = 1'b0;

    typedef struct {
        logic [15:0] val;
        int          gap;
        string       tag;
    } exp_t;
    exp_t exp_q[$];
    bit   sb_on = 1'b0;
    int   last_eop = 0;

    always #10 clk = ~clk;

    ppb_top u0 (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_word(bus_word), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .run(run), .tick(tick),
        .count(count), .eop(eop), .cfg_err(cfg_err)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic push(input logic [15:0] v, input int g, input string t);
        exp_t e;
        e.val = v; e.gap = g; e.tag = t;
        exp_q.push_back(e);
    endtask

    // Driver tasks: called at a negedge, hold for one clock
    task automatic wr_word(input logic addr, input logic [15:0] v);
        bus_wr = 1; bus_word = 1; bus_addr = addr; bus_wdata = v;
        @(negedge clk);
        bus_wr = 0;
    endtask

    task automatic wr_byte(input logic addr, input logic [7:0] v);
        bus_wr = 1; bus_word = 0; bus_addr = addr; bus_wdata = {8'h00, v};
        @(negedge clk);
        bus_wr = 0;
    endtask

    task automatic rd(input logic word, input logic addr, output logic [15:0] v);
        bus_word = word; bus_addr = addr;
        #1 v = bus_rdata;
    endtask

    task automatic wait_eop();
        do @(negedge clk); while (!eop);
    endtask

    // Tick source
    initial begin
        tick = 1'b1;
        forever begin
            @(negedge clk);
            if (tick_alt) tick = ~tick;
            else          tick = 1'b1;
        end
    end

    // Monitor: pops expected reloads and compares at each strobe
    initial begin
        forever begin
            @(negedge clk);
            cyc++;
            if (eop && sb_on) begin
                if (exp_q.size() == 0) begin
                    chk("R8 unexpected eop", 32'd1, 32'd0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    chk({e.tag, " reload value"}, count, e.val);
                    if (e.gap != 0) chk({e.tag, " period"}, cyc - last_eop, e.gap);
                end
                last_eop = cyc;
            end else if (eop && !sb_on) begin
                chk("R11 eop while idle", 32'd1, 32'd0);
            end
        end
    end

    initial begin
        #3_000_000;
        chk("watchdog", 32'd1, 32'd0);
        $display("[TB] %0d tests run, %0d failed", nchk, nfail);
        $finish;
    end

    initial begin
        logic [15:0] v;
        rst = 1; bus_wr = 0; bus_word = 0; bus_addr = 0; bus_wdata = 0; run = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);

        // R1 reset state
        rd(1, 1, v);  chk("R1 period", v, 16'hFFFF);
        chk("R1 count", count, 0);
        chk("R1 eop", eop, 0);
        chk("R1 err", cfg_err, 0);

        // R2/R3 word write and reads
        wr_word(1, 16'h0005);
        rd(1, 1, v);  chk("R2 word readback", v, 16'h0005);
        rd(0, 1, v);  chk("R3 upper byte read", v, 16'h0000);
        rd(0, 0, v);  chk("R3 lower byte read", v, 16'h0005);
        rd(1, 0, v);  chk("R3 word read low addr", v, 16'h0000);

        // R7/R8 start and steady periods
        sb_on = 1;
        push(16'h0005, 0, "R7");
        push(16'h0005, 5, "R8");
        run = 1;
        @(negedge clk);
        chk("R7 start load", count, 16'h0005);
        wait_eop(); wait_eop();

        // R9 change mid-cycle
        push(16'h0007, 5, "R9");
        push(16'h0007, 7, "R9");
        wr_word(1, 16'h0007);
        wait_eop(); wait_eop();

        // R4 upper staged, reload in between uses old period
        push(16'h0007, 7, "R4");
        wr_byte(1, 8'h01);
        rd(0, 1, v);  chk("R4 staged not visible", v, 16'h0000);
        rd(1, 1, v);  chk("R4 period unchanged", v, 16'h0007);
        wait_eop();
        // R5 lower commits both halves
        push(16'h0102, 7, "R5");
        push(16'h0102, 258, "R5");
        wr_byte(0, 8'h02);
        rd(1, 1, v);  chk("R5 committed", v, 16'h0102);
        wait_eop(); wait_eop();

        // R6 lower first: mixed value
        push(16'h0109, 258, "R6");
        wr_byte(0, 8'h09);
        rd(1, 1, v);  chk("R6 low half only", v, 16'h0109);
        wait_eop();
        push(16'h0004, 265, "R5");
        push(16'h0004, 4, "R5");
        wr_byte(1, 8'h00);
        wr_byte(0, 8'h04);
        wait_eop(); wait_eop();

        // R11 stop
        run = 0;
        @(negedge clk);
        sb_on = 0;
        repeat (20) @(negedge clk);
        chk("R11 count idle", count, 0);
        chk("R11 scoreboard drained", exp_q.size(), 0);

        // R10 unusable values
        wr_word(1, 16'h0101);
        chk("R10 err 0101", cfg_err, 1);
        rd(1, 1, v);  chk("R10 stored 0101", v, 16'h0101);
        wr_byte(0, 8'h00);
        chk("R10 err 0100", cfg_err, 0);
        wr_word(1, 16'h0000);
        chk("R10 err 0000", cfg_err, 1);
        wr_word(1, 16'h0004);
        chk("R10 err cleared", cfg_err, 0);

        // R2 word write to low address ignored
        wr_word(0, 16'hABCD);
        rd(1, 1, v);  chk("R2 low-addr word ignored", v, 16'h0004);

        // R8 ticks on alternate clocks
        tick_alt = 1;
        sb_on = 1;
        push(16'h0004, 0, "R8");
        push(16'h0004, 8, "R8 tick");
        push(16'h0004, 8, "R8 tick");
        run = 1;
        wait_eop(); wait_eop(); wait_eop();
        run = 0;
        @(negedge clk);
        sb_on = 0;
        chk("R8 scoreboard drained", exp_q.size(), 0);

        $display("[TB] %0d tests run, %0d failed", nchk, nfail);
        $finish;
    end

endmodule